// File: doc/BRIEF.md
# Storage-to-Storage Byte Move Engine

This block carries out one memory-to-memory character move. A decoder upstream presents the instruction already split into its fields: an 8-bit operation code, an 8-bit length code, and two 16-bit operand address fields. When `start` is pulsed, the engine checks the operation code, turns both address fields into 24-bit effective addresses through a single read port into a 16-entry general register file, and then copies bytes one at a time from the source operand (the second operand) to the destination operand (the first operand).

The byte count comes from the length code alone, which holds the count minus one, so a single move spans 1 to 256 bytes. Memory is reached through two valid/ready request channels, one for reads and one for writes. Back-pressure rules: once the engine raises a request valid, it keeps that valid high and keeps the address (and, for writes, the data) stable until the memory side raises ready in the same cycle. A read handshake delivers `rd_data` in that same cycle. The engine never has both channels active together and issues nothing while idle. Completion is marked by a one-cycle `done` pulse, and an unsupported operation code by a one-cycle `illegal_op` pulse.

Top module: `ss_move_engine`

## Requirements
- R1: Only operation code 0xD2 starts a move. Any other code seen with `start` while idle gives a one-cycle `illegal_op` pulse in the next cycle, with `busy` staying low and no read or write request issued.
- R2: A length code of N moves exactly N+1 bytes, so 0x00 moves one byte and 0xFF moves 256 bytes.
- R3: In each address field, bits [15:12] select a base register and bits [11:0] are an unsigned displacement. The effective address is base register contents plus the zero-extended displacement, modulo 2^24.
- R4: Base register number 0 adds zero to the displacement, whatever register 0 holds.
- R5: Byte k is read from source address + k and then written unchanged to destination address + k, for k ascending from 0 (both addresses modulo 2^24). The read handshake for byte k comes before the write handshake for byte k.
- R6: A raised `rd_valid` or `wr_valid` stays high, with its address and data stable, until the matching ready is seen. The two valids are never high together, and neither is high while `busy` is low.
- R7: `busy` is high from the cycle after an accepted start until the final write handshake. `done` is high for exactly the one cycle after that handshake, and `busy` is low in that cycle.
- R8: `start` is ignored while `busy` is high. The move in progress keeps its own byte count and addresses.
- R9: The destination base is resolved in the first cycle after an accepted start and the source base in the second. The first read request is raised in the third cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse to present a decoded instruction |
| opcode | input | 8 | Operation code field |
| len_code | input | 8 | Byte count minus one |
| dst_field | input | 16 | Destination operand: base number and displacement |
| src_field | input | 16 | Source operand: base number and displacement |
| gpr_sel | output | 4 | Register file read index |
| gpr_data | input | 24 | Register file read data, combinational from `gpr_sel` |
| rd_valid | output | 1 | Byte read request |
| rd_addr | output | 24 | Byte read address |
| rd_ready | input | 1 | Read accepted; `rd_data` valid this cycle |
| rd_data | input | 8 | Byte read data |
| wr_valid | output | 1 | Byte write request |
| wr_addr | output | 24 | Byte write address |
| wr_data | output | 8 | Byte write data |
| wr_ready | input | 1 | Write accepted |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal_op | output | 1 | One-cycle unsupported-code pulse |

## Verification
`illegal_op` is due one clock edge after the start edge, and `busy` also changes at that edge. `rd_valid` stays low after the first and second edges and rises after the third, while `done` appears one edge after the last write handshake and is gone one edge later. The bench drives inputs on falling edges and samples on the falling edge that follows each of those rising edges, so every value is read exactly one register stage after its cause. The memory model logs each handshake with its address on the rising edge. Addresses, order and data are then compared with values the bench computes from the register contents and field values it supplied, including a run with stalled ready signals.

// File: rtl/ss_move_pkg.sv
package ss_move_pkg;

  // operation code accepted by the engine
  localparam logic [7:0] MOVE_OPC = 8'hD2;

  typedef enum logic [2:0] {
    MV_IDLE,
    MV_BASE_DST,
    MV_BASE_SRC,
    MV_READ,
    MV_WRITE
  } mv_state_e;

endpackage

// File: rtl/ss_move_ea.sv
// Effective address: base register contents plus zero-extended displacement.
module ss_move_ea #(
  parameter int ADDR_W        = 24,
  parameter int RSEL_W        = 4,
  parameter int DISP_W        = 12,
  parameter bit ZERO_BASE_NUL = 1'b1
) (
  input  logic [RSEL_W-1:0] base_num,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea
);

  localparam int PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{PAD_W{1'b0}}, disp};

  generate
    if (ZERO_BASE_NUL) begin : g_nul_base
      // register number 0 stands for "no base"
      assign base_term = (base_num == '0) ? '0 : base_val;
    end else begin : g_plain_base
      logic unused_num;
      assign unused_num = ^base_num;
      assign base_term  = base_val;
    end
  endgenerate

  // carry out of the top bit is dropped: wraps modulo 2^ADDR_W
  assign ea = base_term + disp_ext;

endmodule

// File: rtl/ss_move_fsm.sv
// Sequencer: base resolution, then alternating read and write per byte.
module ss_move_fsm
  import ss_move_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      opc_ok,
  input  logic      rd_ready,
  input  logic      wr_ready,
  input  logic      last,
  output mv_state_e state,
  output logic      accept,
  output logic      done,
  output logic      illegal
);

  mv_state_e nxt;
  logic      final_ack;

  always_comb begin
    accept    = (state == MV_IDLE) && start && opc_ok;
    final_ack = (state == MV_WRITE) && wr_ready && last;
    nxt       = state;
    case (state)
      MV_IDLE:     if (accept) nxt = MV_BASE_DST;
      MV_BASE_DST: nxt = MV_BASE_SRC;
      MV_BASE_SRC: nxt = MV_READ;
      MV_READ:     if (rd_ready) nxt = MV_WRITE;
      MV_WRITE:    if (wr_ready) nxt = last ? MV_IDLE : MV_READ;
      default:     nxt = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= MV_IDLE;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      state   <= nxt;
      done    <= final_ack;
      illegal <= (state == MV_IDLE) && start && !opc_ok;
    end
  end

endmodule

// File: rtl/ss_move_dp.sv
// Datapath: latched fields, address pointers, remaining count, byte buffer.
module ss_move_dp
  import ss_move_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8,
  parameter int RSEL_W = 4,
  parameter int DISP_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  mv_state_e                state,
  input  logic                     accept,
  input  logic [LEN_W-1:0]         len_code,
  input  logic [RSEL_W+DISP_W-1:0] dst_field,
  input  logic [RSEL_W+DISP_W-1:0] src_field,
  input  logic [ADDR_W-1:0]        gpr_data,
  input  logic                     rd_ready,
  input  logic [DATA_W-1:0]        rd_data,
  input  logic                     wr_ready,
  output logic [RSEL_W-1:0]        gpr_sel,
  output logic [ADDR_W-1:0]        dst_ptr,
  output logic [ADDR_W-1:0]        src_ptr,
  output logic [DATA_W-1:0]        byte_q,
  output logic                     last
);

  localparam int FIELD_W = RSEL_W + DISP_W;

  logic [FIELD_W-1:0] dst_f;
  logic [FIELD_W-1:0] src_f;
  logic [FIELD_W-1:0] cur_f;
  logic [LEN_W-1:0]   remain;
  logic [ADDR_W-1:0]  ea;

  // one read port serves both operands, one per cycle
  assign cur_f   = (state == MV_BASE_SRC) ? src_f : dst_f;
  assign gpr_sel = cur_f[FIELD_W-1 -: RSEL_W];
  assign last    = (remain == '0);

  ss_move_ea #(
    .ADDR_W       (ADDR_W),
    .RSEL_W       (RSEL_W),
    .DISP_W       (DISP_W),
    .ZERO_BASE_NUL(1'b1)
  ) u_ea (
    .base_num(gpr_sel),
    .base_val(gpr_data),
    .disp    (cur_f[DISP_W-1:0]),
    .ea      (ea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_f   <= '0;
      src_f   <= '0;
      remain  <= '0;
      dst_ptr <= '0;
      src_ptr <= '0;
      byte_q  <= '0;
    end else begin
      if (accept) begin
        dst_f  <= dst_field;
        src_f  <= src_field;
        remain <= len_code;
      end
      case (state)
        MV_BASE_DST: dst_ptr <= ea;
        MV_BASE_SRC: src_ptr <= ea;
        MV_READ:     if (rd_ready) byte_q <= rd_data;
        MV_WRITE: begin
          if (wr_ready && !last) begin
            remain  <= remain - 1'b1;
            dst_ptr <= dst_ptr + 1'b1;
            src_ptr <= src_ptr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ss_move_engine.sv
// Top: storage-to-storage byte move engine.
module ss_move_engine
  import ss_move_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8,
  parameter int RSEL_W = 4,
  parameter int DISP_W = 12,
  parameter int DATA_W = 8,
  parameter int OPC_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [OPC_W-1:0]         opcode,
  input  logic [LEN_W-1:0]         len_code,
  input  logic [RSEL_W+DISP_W-1:0] dst_field,
  input  logic [RSEL_W+DISP_W-1:0] src_field,
  output logic [RSEL_W-1:0]        gpr_sel,
  input  logic [ADDR_W-1:0]        gpr_data,
  output logic                     rd_valid,
  output logic [ADDR_W-1:0]        rd_addr,
  input  logic                     rd_ready,
  input  logic [DATA_W-1:0]        rd_data,
  output logic                     wr_valid,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [DATA_W-1:0]        wr_data,
  input  logic                     wr_ready,
  output logic                     busy,
  output logic                     done,
  output logic                     illegal_op
);

  mv_state_e         state;
  logic              accept;
  logic              opc_ok;
  logic              last;
  logic [ADDR_W-1:0] dst_ptr;
  logic [ADDR_W-1:0] src_ptr;
  logic [DATA_W-1:0] byte_q;

  assign opc_ok = (opcode == OPC_W'(MOVE_OPC));

  ss_move_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opc_ok  (opc_ok),
    .rd_ready(rd_ready),
    .wr_ready(wr_ready),
    .last    (last),
    .state   (state),
    .accept  (accept),
    .done    (done),
    .illegal (illegal_op)
  );

  ss_move_dp #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .RSEL_W(RSEL_W),
    .DISP_W(DISP_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .accept   (accept),
    .len_code (len_code),
    .dst_field(dst_field),
    .src_field(src_field),
    .gpr_data (gpr_data),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .wr_ready (wr_ready),
    .gpr_sel  (gpr_sel),
    .dst_ptr  (dst_ptr),
    .src_ptr  (src_ptr),
    .byte_q   (byte_q),
    .last     (last)
  );

  // requests are plain decodes of the state register: stable while waiting
  assign rd_valid = (state == MV_READ);
  assign rd_addr  = src_ptr;
  assign wr_valid = (state == MV_WRITE);
  assign wr_addr  = dst_ptr;
  assign wr_data  = byte_q;
  assign busy     = (state != MV_IDLE);

endmodule

// File: rtl/ss_move_checker.sv
// Protocol and sequencing properties, bound to the top module.
module ss_move_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              done,
  input logic              illegal_op
);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_one_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid && !wr_valid);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid && wr_ready) && !busy);

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_illegal_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> !busy && !rd_valid && !wr_valid);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

bind ss_move_engine ss_move_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .busy      (busy),
  .done      (done),
  .illegal_op(illegal_op)
);

// File: tb/tb_ss_move_engine.sv
`timescale 1ns/1ps
module tb_ss_move_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  len_code = 8'h00;
  logic [15:0] dst_field = 16'h0;
  logic [15:0] src_field = 16'h0;
  logic [3:0]  gpr_sel;
  logic [23:0] gpr_data;
  logic        rd_valid, rd_ready;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data;
  logic        wr_valid, wr_ready;
  logic [23:0] wr_addr;
  logic [7:0]  wr_data;
  logic        busy, done, illegal_op;

  int checks = 0;
  int errors = 0;

  // 200 MHz
  always #2.5 clk = ~clk;

  ss_move_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .len_code(len_code), .dst_field(dst_field), .src_field(src_field),
    .gpr_sel(gpr_sel), .gpr_data(gpr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .busy(busy), .done(done), .illegal_op(illegal_op)
  );

  // ---------------- register file and memory model ----------------
  logic [23:0] gpr [0:15];
  assign gpr_data = gpr[gpr_sel];

  logic [7:0]  mem [0:4095];
  logic [23:0] wlog [0:511];
  logic [23:0] rlog [0:511];
  int          rd_cnt = 0, wr_cnt = 0, ord_err = 0;
  logic        clr = 1'b0;
  logic [7:0]  seed = 8'h00;
  logic        stall_en = 1'b0;
  logic [1:0]  ph = 2'd0;

  function automatic logic [7:0] pat(input logic [23:0] a, input logic [7:0] s);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ s ^ 8'h5A;
  endfunction

  assign rd_ready = !stall_en || (ph == 2'd3);
  assign wr_ready = !stall_en || ph[0];
  assign rd_data  = mem[rd_addr[11:0]];

  always @(posedge clk) begin
    ph <= ph + 2'd1;
    if (clr) begin
      rd_cnt  = 0;
      wr_cnt  = 0;
      ord_err = 0;
      for (int i = 0; i < 4096; i++) mem[i] = pat(24'(i), seed);
    end else begin
      if (rd_valid && rd_ready) begin
        if (rd_cnt < 512) rlog[rd_cnt] = rd_addr;
        rd_cnt++;
      end
      if (wr_valid && wr_ready) begin
        if (rd_cnt != wr_cnt + 1) ord_err++;
        if (wr_cnt < 512) wlog[wr_cnt] = wr_addr;
        mem[wr_addr[11:0]] = wr_data;
        wr_cnt++;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log(input logic [7:0] s);
    @(negedge clk);
    seed = s;
    clr  = 1'b1;
    @(negedge clk);
    clr  = 1'b0;
  endtask

  // Issue a move and follow it to done; optional start pulse while busy.
  task automatic run_move(input logic [7:0] opc, input logic [7:0] len,
                          input logic [15:0] f1, input logic [15:0] f2,
                          input bit bump);
    int cyc;
    @(negedge clk);
    start = 1'b1; opcode = opc; len_code = len; dst_field = f1; src_field = f2;
    @(negedge clk);
    start = 1'b0;
    check("R7", "busy after start", busy, 1'b1);
    check("R9", "no read in dst base cycle", rd_valid, 1'b0);
    @(negedge clk);
    check("R9", "no read in src base cycle", rd_valid, 1'b0);
    if (bump) begin
      start = 1'b1; opcode = 8'hD2; len_code = 8'h09;
      dst_field = 16'h0000; src_field = 16'h0010;
    end
    @(negedge clk);
    start = 1'b0;
    check("R9", "read request third cycle", rd_valid, 1'b1);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check("R7", "done reached", done, 1'b1);
    check("R7", "busy low with done", busy, 1'b0);
    @(negedge clk);
    check("R7", "done one cycle", done, 1'b0);
  endtask

  task automatic verify(input string req, input logic [23:0] dst,
                        input logic [23:0] src, input int n);
    int bad_w, bad_r, bad_d;
    logic [23:0] da, sa;
    bad_w = 0; bad_r = 0; bad_d = 0;
    check("R2", "write count", wr_cnt, n);
    check("R2", "read count", rd_cnt, n);
    check("R5", "read before write per byte", ord_err, 0);
    for (int k = 0; k < n; k++) begin
      da = dst + 24'(k);
      sa = src + 24'(k);
      if (wlog[k] !== da) bad_w++;
      if (rlog[k] !== sa) bad_r++;
      if (mem[da[11:0]] !== pat(sa, seed)) bad_d++;
    end
    check(req, "dest address sequence mismatches", bad_w, 0);
    check(req, "src address sequence mismatches", bad_r, 0);
    check("R5", "copied data mismatches", bad_d, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R7", "reset busy", busy, 1'b0);
    check("R7", "reset done", done, 1'b0);
    check("R1", "reset illegal", illegal_op, 1'b0);
    check("R6", "reset rd_valid", rd_valid, 1'b0);
    check("R6", "reset wr_valid", wr_valid, 1'b0);
  endtask

  // R3: 8 bytes, both bases register 12
  task automatic t_basic();
    clear_log(8'h11);
    gpr[12] = 24'h001000;
    run_move(8'hD2, 8'h07, 16'hC008, 16'hC020, 1'b0);
    verify("R3", 24'h001008, 24'h001020, 8);
  endtask

  // R4: base 0 means no base; length 0 moves one byte (R2)
  task automatic t_base_zero();
    clear_log(8'h22);
    gpr[0] = 24'h000700;
    run_move(8'hD2, 8'h00, 16'h0300, 16'h0400, 1'b0);
    verify("R4", 24'h000300, 24'h000400, 1);
  endtask

  // R2: 256 bytes under read and write back-pressure (R6)
  task automatic t_long_stall();
    clear_log(8'h33);
    gpr[3] = 24'h000200;
    gpr[5] = 24'h000900;
    stall_en = 1'b1;
    run_move(8'hD2, 8'hFF, 16'h3100, 16'h5050, 1'b0);
    stall_en = 1'b0;
    verify("R2", 24'h000300, 24'h000950, 256);
  endtask

  // R3: destination wraps past 2^24, max displacement on source
  task automatic t_wrap();
    clear_log(8'h44);
    gpr[14] = 24'hFFFFF0;
    gpr[7]  = 24'h000100;
    run_move(8'hD2, 8'h0F, 16'hE008, 16'h7FFF, 1'b0);
    verify("R3", 24'hFFFFF8, 24'h0010FF, 16);
  endtask

  // R1: unsupported code
  task automatic t_illegal();
    clear_log(8'h55);
    @(negedge clk);
    start = 1'b1; opcode = 8'hFA; len_code = 8'h03;
    dst_field = 16'hC300; src_field = 16'hC304;
    @(negedge clk);
    start = 1'b0;
    check("R1", "illegal pulse", illegal_op, 1'b1);
    check("R1", "busy stays low", busy, 1'b0);
    @(negedge clk);
    check("R1", "illegal one cycle", illegal_op, 1'b0);
    repeat (6) @(negedge clk);
    check("R1", "no reads", rd_cnt, 0);
    check("R1", "no writes", wr_cnt, 0);
    check("R1", "still idle", busy, 1'b0);
  endtask

  // R8: start while busy does not disturb the move
  task automatic t_busy_start();
    clear_log(8'h66);
    gpr[2] = 24'h000A00;
    run_move(8'hD2, 8'h03, 16'h2000, 16'h2040, 1'b1);
    verify("R8", 24'h000A00, 24'h000A40, 4);
    repeat (4) @(negedge clk);
    check("R8", "no second move", busy, 1'b0);
  endtask

  // ---------------- main ----------------
  initial begin
    for (int i = 0; i < 16; i++) gpr[i] = 24'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_base_zero();
    t_long_stall();
    t_wrap();
    t_illegal();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule